// File: doc/BRIEF.md
# Paging Decoder Shutdown Sequencer

This block sits on the host side of a paging-protocol receiver. It switches the receiver's decoder off safely. A single clean "off" command is not enough, because the decoder may ignore on/off changes that arrive too close together. The block therefore issues three control packets in a fixed order: off, then on, then off again. It spaces them using millisecond ticks supplied from outside.

A shutdown request makes the block latch two totals from the programmed settings tables:

- the shutdown time, which sets the earliest moment the "on" packet may follow the first "off";
- the warm-up time, which sets the latest moment the final "off" must complete after the "on".

For each packet the block raises a send request that carries the on/off value. It holds that request until the external packet serialiser returns a one-cycle completion strobe. The block reports the result with a one-cycle success pulse or, if the final window is missed, a one-cycle error pulse.

Top module: `pdsq_shutdown_seq`

## Requirements
- R1: In idle, a high `seq_start_i` at a clock edge makes the block assert `busy_o` and `pkt_req_o` with `pkt_on_o` = 0 from the next cycle.
- R2: A packet request stays high with an unchanged `pkt_on_o` until the edge at which `pkt_done_i` is sampled high. The request is low from the following cycle, except when R7 aborts.
- R3: After the first off packet completes, the on packet (`pkt_on_o` = 1) is requested once exactly max(2, shutdown total) ticks have been counted. Counted ticks are those sampled after the completion edge; a tick at the completion edge itself is not counted.
- R4: Each settings table packs its entries as `TIME_W`-bit fields, with entry i at bits [i*TIME_W +: TIME_W]. Its total is the sum of the entries whose bit i in the matching used mask is 1.
- R5: After the on packet completes, the final off packet (`pkt_on_o` = 0) is requested once 2 ticks have been counted, using the same counting rule as R3.
- R6: The warm-up limit is the warm-up total minus 2, saturating at 0. If the final off packet completes while the tick count since the on packet's completion is at most this limit, `seq_done_o` pulses for one cycle and the block returns to idle.
- R7: Before the final off packet completes, a tick sampled while the count already equals or exceeds the warm-up limit ends the sequence. The abort happens whether the block is waiting or sending, unless completion is sampled at that same edge. From the next cycle `seq_err_o` pulses, the request drops, the block returns to idle, and `seq_done_o` stays low.
- R8: While `busy_o` is high, `seq_start_i` is ignored. Changes to the settings tables also have no effect, because the limits are latched at the start edge.
- R9: During and right after synchronous reset, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| seq_start_i | input | 1 | Shutdown request |
| ms_tick_i | input | 1 | One-cycle millisecond tick |
| shut_times_i | input | N_SHUT*TIME_W | Shutdown settings entries |
| shut_used_i | input | N_SHUT | Shutdown entry in-use mask |
| warm_times_i | input | N_WARM*TIME_W | Warm-up settings entries |
| warm_used_i | input | N_WARM | Warm-up entry in-use mask |
| pkt_done_i | input | 1 | Packet completion strobe from the serialiser |
| pkt_req_o | output | 1 | Packet send request |
| pkt_on_o | output | 1 | On/off bit value carried by the request |
| busy_o | output | 1 | Sequence in progress |
| seq_done_o | output | 1 | One-cycle success pulse |
| seq_err_o | output | 1 | One-cycle window-miss pulse |

## Verification
A wrong state or a wrong tick count appears at the ports within one cycle of the edge where it arises. It shows up as one of:

- a request that rises a tick too early or too late;
- a wrong on/off value;
- a request that drops without a completion;
- a success or error pulse with the wrong polarity or in the wrong cycle.

The bench keeps a cycle-level model of the sequence derived from the requirements and compares every output in every cycle. Even a single miscounted tick therefore shows up at the next request edge or at the warm-up boundary. The off-by-one cases exercised are ticks that coincide with completion strobes, small totals that round up to 2, and a warm-up total of 0, 3 or 4.

// File: rtl/pdsq_pkg.sv
package pdsq_pkg;

  // Sequence phases: idle, three packet sends and two timed holds.
  typedef enum logic [2:0] {
    S_IDLE  = 3'd0,
    S_OFF1  = 3'd1,
    S_HOLD1 = 3'd2,
    S_ON2   = 3'd3,
    S_HOLD2 = 3'd4,
    S_OFF3  = 3'd5
  } seq_state_t;

endpackage

// File: rtl/pdsq_time_sum.sv
// Adds up the entries of one settings table whose used bit is set (R4).
module pdsq_time_sum #(
  parameter int N     = 4,
  parameter int W     = 8,
  parameter int SUM_W = 11
) (
  input  logic [N*W-1:0] times_i,
  input  logic [N-1:0]   used_i,
  output logic [SUM_W-1:0] sum_o
);

  logic [SUM_W-1:0] part [N+1];

  assign part[0] = '0;

  for (genvar g = 0; g < N; g++) begin : g_acc
    logic [SUM_W-1:0] term;
    assign term       = used_i[g] ? SUM_W'(times_i[g*W +: W]) : '0;
    assign part[g+1]  = part[g] + term;
  end

  assign sum_o = part[N];

endmodule

// File: rtl/pdsq_window_calc.sv
// Derives the first-gap minimum (R3) and the warm-up ceiling (R6).
module pdsq_window_calc #(
  parameter int SUM_W   = 11,
  parameter int CNT_W   = 12,
  parameter int MIN_GAP = 2
) (
  input  logic [SUM_W-1:0] shut_sum_i,
  input  logic [SUM_W-1:0] warm_sum_i,
  output logic [CNT_W-1:0] min1_o,
  output logic [CNT_W-1:0] wmax_o
);

  localparam logic [CNT_W-1:0] GAP = CNT_W'(MIN_GAP);

  logic [CNT_W-1:0] shut_ext;
  logic [CNT_W-1:0] warm_ext;

  assign shut_ext = CNT_W'(shut_sum_i);
  assign warm_ext = CNT_W'(warm_sum_i);

  always_comb begin
    min1_o = (shut_ext < GAP) ? GAP : shut_ext;
    wmax_o = (warm_ext > GAP) ? (warm_ext - GAP) : '0;
  end

endmodule

// File: rtl/pdsq_gap_timer.sv
// Saturating tick counter, zeroed at the edge of a packet completion.
module pdsq_gap_timer #(
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr_i,
  input  logic             tick_i,
  output logic [CNT_W-1:0] cnt_o
);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_o <= '0;
    end else if (clr_i) begin
      cnt_o <= '0;
    end else if (tick_i && (cnt_o != '1)) begin
      cnt_o <= cnt_o + 1'b1;
    end
  end

  // R3: the gap count starts from zero after a completion edge
  a_r3_clear_to_zero: assert property (@(posedge clk) disable iff (rst)
    clr_i |=> (cnt_o == '0));

  // R5: with no tick and no clear the count does not move
  a_r5_count_holds: assert property (@(posedge clk) disable iff (rst)
    (!clr_i && !tick_i) |=> $stable(cnt_o));

endmodule

// File: rtl/pdsq_seq_fsm.sv
module pdsq_seq_fsm
  import pdsq_pkg::*;
#(
  parameter int CNT_W   = 12,
  parameter int MIN_GAP = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_i,
  input  logic             tick_i,
  input  logic             done_i,
  input  logic [CNT_W-1:0] min1_i,
  input  logic [CNT_W-1:0] wmax_i,
  input  logic [CNT_W-1:0] cnt_i,
  output logic             timer_clr_o,
  output logic             pkt_req_o,
  output logic             pkt_on_o,
  output logic             busy_o,
  output logic             seq_done_o,
  output logic             seq_err_o
);

  localparam logic [CNT_W-1:0] GAP = CNT_W'(MIN_GAP);

  seq_state_t       st_q, st_d;
  logic [CNT_W-1:0] min1_q, wmax_q;
  logic             ok_d, err_d, wmax_hit;

  assign wmax_hit = tick_i && (cnt_i >= wmax_q);

  always_comb begin
    st_d        = st_q;
    ok_d        = 1'b0;
    err_d       = 1'b0;
    timer_clr_o = 1'b0;
    case (st_q)
      S_IDLE:  if (start_i) st_d = S_OFF1;
      S_OFF1:  if (done_i) begin
                 st_d        = S_HOLD1;
                 timer_clr_o = 1'b1;
               end
      S_HOLD1: if (cnt_i >= min1_q) st_d = S_ON2;
      S_ON2:   if (done_i) begin
                 st_d        = S_HOLD2;
                 timer_clr_o = 1'b1;
               end
      S_HOLD2: if (wmax_hit) begin
                 st_d  = S_IDLE;
                 err_d = 1'b1;
               end else if (cnt_i >= GAP) begin
                 st_d = S_OFF3;
               end
      S_OFF3:  if (done_i) begin
                 st_d = S_IDLE;
                 ok_d = 1'b1;
               end else if (wmax_hit) begin
                 st_d  = S_IDLE;
                 err_d = 1'b1;
               end
      default: st_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q       <= S_IDLE;
      min1_q     <= '0;
      wmax_q     <= '0;
      pkt_req_o  <= 1'b0;
      pkt_on_o   <= 1'b0;
      busy_o     <= 1'b0;
      seq_done_o <= 1'b0;
      seq_err_o  <= 1'b0;
    end else begin
      st_q <= st_d;
      if ((st_q == S_IDLE) && start_i) begin
        min1_q <= min1_i;
        wmax_q <= wmax_i;
      end
      pkt_req_o  <= (st_d == S_OFF1) || (st_d == S_ON2) || (st_d == S_OFF3);
      pkt_on_o   <= (st_d == S_ON2);
      busy_o     <= (st_d != S_IDLE);
      seq_done_o <= ok_d;
      seq_err_o  <= err_d;
    end
  end

  // R1: a new sequence always opens with an off packet
  a_r1_first_is_off: assert property (@(posedge clk) disable iff (rst)
    $rose(busy_o) |-> (pkt_req_o && !pkt_on_o));

  // R2: a request only falls after a completion, or on an abort
  a_r2_drop_needs_done: assert property (@(posedge clk) disable iff (rst)
    ($past(pkt_req_o) && !$past(done_i) && !pkt_req_o) |-> seq_err_o);

  // R6: success only follows completion of an off packet
  a_r6_done_after_off: assert property (@(posedge clk) disable iff (rst)
    seq_done_o |-> ($past(pkt_req_o) && !$past(pkt_on_o) && $past(done_i)));

  // R7: an abort is caused by a tick without a completion
  a_r7_err_on_tick: assert property (@(posedge clk) disable iff (rst)
    seq_err_o |-> ($past(tick_i) && !$past(done_i)));

  // R7: success and error never coincide
  a_r7_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(seq_done_o && seq_err_o));

  // R8: a start request while busy does not end the sequence
  a_r8_start_ignored: assert property (@(posedge clk) disable iff (rst)
    (busy_o && start_i && !done_i && !tick_i) |=> busy_o);

endmodule

// File: rtl/pdsq_shutdown_seq.sv
module pdsq_shutdown_seq #(
  parameter int N_SHUT  = 4,
  parameter int N_WARM  = 4,
  parameter int TIME_W  = 8,
  parameter int MIN_GAP = 2
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     seq_start_i,
  input  logic                     ms_tick_i,
  input  logic [N_SHUT*TIME_W-1:0] shut_times_i,
  input  logic [N_SHUT-1:0]        shut_used_i,
  input  logic [N_WARM*TIME_W-1:0] warm_times_i,
  input  logic [N_WARM-1:0]        warm_used_i,
  input  logic                     pkt_done_i,
  output logic                     pkt_req_o,
  output logic                     pkt_on_o,
  output logic                     busy_o,
  output logic                     seq_done_o,
  output logic                     seq_err_o
);

  localparam int MAX_N = (N_SHUT > N_WARM) ? N_SHUT : N_WARM;
  localparam int SUM_W = TIME_W + $clog2(MAX_N + 1);
  localparam int CNT_W = SUM_W + 1;

  logic [SUM_W-1:0] shut_sum, warm_sum;
  logic [CNT_W-1:0] min1, wmax, gap_cnt;
  logic             timer_clr;

  pdsq_time_sum #(.N(N_SHUT), .W(TIME_W), .SUM_W(SUM_W)) u_shut_sum (
    .times_i (shut_times_i),
    .used_i  (shut_used_i),
    .sum_o   (shut_sum)
  );

  pdsq_time_sum #(.N(N_WARM), .W(TIME_W), .SUM_W(SUM_W)) u_warm_sum (
    .times_i (warm_times_i),
    .used_i  (warm_used_i),
    .sum_o   (warm_sum)
  );

  pdsq_window_calc #(.SUM_W(SUM_W), .CNT_W(CNT_W), .MIN_GAP(MIN_GAP)) u_win (
    .shut_sum_i (shut_sum),
    .warm_sum_i (warm_sum),
    .min1_o     (min1),
    .wmax_o     (wmax)
  );

  pdsq_gap_timer #(.CNT_W(CNT_W)) u_timer (
    .clk    (clk),
    .rst    (rst),
    .clr_i  (timer_clr),
    .tick_i (ms_tick_i),
    .cnt_o  (gap_cnt)
  );

  pdsq_seq_fsm #(.CNT_W(CNT_W), .MIN_GAP(MIN_GAP)) u_fsm (
    .clk         (clk),
    .rst         (rst),
    .start_i     (seq_start_i),
    .tick_i      (ms_tick_i),
    .done_i      (pkt_done_i),
    .min1_i      (min1),
    .wmax_i      (wmax),
    .cnt_i       (gap_cnt),
    .timer_clr_o (timer_clr),
    .pkt_req_o   (pkt_req_o),
    .pkt_on_o    (pkt_on_o),
    .busy_o      (busy_o),
    .seq_done_o  (seq_done_o),
    .seq_err_o   (seq_err_o)
  );

endmodule

// File: tb/pdsq_shutdown_seq_tb_top.sv
module pdsq_shutdown_seq_tb_top;

  localparam int NS = 4, NW = 4, TW = 8, MING = 2, TP = 4;

  logic clk = 1'b0, rst = 1'b1, start = 1'b0, tick = 1'b0, pdone = 1'b0;
  logic [NS*TW-1:0] shut_t = '0;
  logic [NS-1:0]    shut_u = '0;
  logic [NW*TW-1:0] warm_t = '0;
  logic [NW-1:0]    warm_u = '0;
  logic req, on, busy, sdone, serr;

  always #5 clk = ~clk;

  pdsq_shutdown_seq #(.N_SHUT(NS), .N_WARM(NW), .TIME_W(TW), .MIN_GAP(MING)) dut_i (
    .clk(clk), .rst(rst), .seq_start_i(start), .ms_tick_i(tick),
    .shut_times_i(shut_t), .shut_used_i(shut_u),
    .warm_times_i(warm_t), .warm_used_i(warm_u),
    .pkt_done_i(pdone), .pkt_req_o(req), .pkt_on_o(on), .busy_o(busy),
    .seq_done_o(sdone), .seq_err_o(serr)
  );

  int n_chk = 0, n_fail = 0, tick_ph = 0;
  int m_ph = 0, m_cnt = 0, m_min1 = 0, m_wmax = 0, m_lat = 0, lat_n = 2, lat3 = 2;
  bit exp_done = 0, exp_err = 0, finished = 0;

  task automatic chk(string tag, string what, logic act, logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s act=%0b exp=%0b t=%0t", tag, what, act, exp, $time);
    end
  endtask

  function automatic string tag_of(int ph);
    case (ph)
      1: return "R1";
      2: return "R3 R4";
      3: return "R3";
      4: return "R5";
      5: return "R5";
      default: return "R2";
    endcase
  endfunction

  // R4: sum of entries whose used bit is set
  function automatic int sum_used(logic [31:0] v, logic [3:0] u);
    int s = 0;
    for (int i = 0; i < 4; i++) if (u[i]) s += int'(v[i*8 +: 8]);
    return s;
  endfunction

  function automatic logic [31:0] rnd_tab(int lim);
    logic [31:0] v;
    for (int i = 0; i < 4; i++) v[i*8 +: 8] = 8'($urandom % lim);
    return v;
  endfunction

  task automatic step(bit st, bit scramble);
    int old;
    tick  = (tick_ph == 0);
    tick_ph = (tick_ph + 1) % TP;
    pdone = ((m_ph == 1) || (m_ph == 3) || (m_ph == 5)) && (m_lat == 0);
    start = st;
    if (scramble && m_ph != 0) begin   // R8: latched limits ignore these
      shut_t = rnd_tab(256); shut_u = 4'($urandom);
      warm_t = rnd_tab(256); warm_u = 4'($urandom);
    end
    @(posedge clk);
    exp_done = 0; exp_err = 0;
    old = m_cnt;
    case (m_ph)
      0: if (st) begin
           m_min1 = sum_used(shut_t, shut_u);
           if (m_min1 < MING) m_min1 = MING;
           m_wmax = sum_used(warm_t, warm_u) - MING;
           if (m_wmax < 0) m_wmax = 0;
           m_ph = 1; m_lat = lat_n;
         end
      1: if (pdone) begin m_ph = 2; m_cnt = 0; end else m_lat--;
      2: if (old >= m_min1) begin m_ph = 3; m_lat = lat_n; end
         else if (tick) m_cnt++;
      3: if (pdone) begin m_ph = 4; m_cnt = 0; end else m_lat--;
      4: if (tick && old >= m_wmax) begin exp_err = 1; m_ph = 0; end
         else begin
           if (old >= MING) begin m_ph = 5; m_lat = lat3; end
           if (tick) m_cnt++;
         end
      5: if (pdone) begin exp_done = 1; m_ph = 0; end
         else if (tick && old >= m_wmax) begin exp_err = 1; m_ph = 0; end
         else begin if (tick) m_cnt++; m_lat--; end
      default: m_ph = 0;
    endcase
    @(negedge clk);
    pdone = 0; start = 0;
    chk(tag_of(m_ph), "pkt_req", req, (m_ph == 1 || m_ph == 3 || m_ph == 5));
    if (m_ph == 1 || m_ph == 3 || m_ph == 5) chk(tag_of(m_ph), "pkt_on", on, (m_ph == 3));
    chk("R8", "busy", busy, (m_ph != 0));
    chk("R6", "seq_done", sdone, exp_done);
    chk("R7", "seq_err", serr, exp_err);
  endtask

  task automatic run_seq(logic [31:0] st_, logic [3:0] su, logic [31:0] wt, logic [3:0] wu,
                         int ln, int l3, bit noise);
    shut_t = st_; shut_u = su; warm_t = wt; warm_u = wu;
    lat_n = ln; lat3 = l3;
    step(1'b1, 1'b0);
    while (m_ph != 0)
      step(noise && ($urandom % 16 == 0), noise && ($urandom % 8 == 0));
    step(1'b0, 1'b0);
    step(1'b0, 1'b0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL R9 watchdog act=hung exp=finished");
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    rst = 1'b1;
    repeat (4) @(negedge clk);
    // R9: outputs low during reset
    chk("R9", "req in reset", req, 1'b0);
    chk("R9", "busy in reset", busy, 1'b0);
    rst = 1'b0;
    @(negedge clk);
    chk("R9", "req after reset", req, 1'b0);
    chk("R9", "on after reset", on, 1'b0);
    chk("R9", "done after reset", sdone, 1'b0);
    chk("R9", "err after reset", serr, 1'b0);
    // R3 R4: no shutdown entries used -> minimum of 2
    run_seq(32'h0F0F0F0F, 4'b0000, 32'h05050505, 4'b0011, 2, 2, 0);
    // R3: total of 1 rounds up to 2
    run_seq(32'h00000100, 4'b0010, 32'h0A000000, 4'b1000, 1, 1, 0);
    // R4: partial mask, unused entries large
    run_seq(32'hFF04FF05, 4'b0101, 32'h06FF0600, 4'b1010, 3, 3, 0);
    // R7: warm-up total 0 -> abort on first tick in hold
    run_seq(32'h00000003, 4'b0001, 32'h09090909, 4'b0000, 2, 2, 0);
    // R7: warm-up total 3 -> limit 1
    run_seq(32'h00000003, 4'b0001, 32'h00000003, 4'b0001, 2, 2, 0);
    // R6: warm-up total 4 -> limit 2, tight boundary
    run_seq(32'h00000002, 4'b0001, 32'h00000004, 4'b0001, 1, 1, 0);
    run_seq(32'h00000002, 4'b0001, 32'h00000004, 4'b0001, 2, 0, 0);
    // R7: final packet too slow
    run_seq(32'h00000004, 4'b0001, 32'h00000008, 4'b0001, 2, 300, 0);
    // random sequences with start noise and table scrambling (R8)
    for (int k = 0; k < 30; k++) begin
      int l3r;
      l3r = ($urandom % 5 == 0) ? 60 + int'($urandom % 60) : int'($urandom % 6);
      run_seq(rnd_tab(16), 4'($urandom), rnd_tab(12), 4'($urandom),
              1 + int'($urandom % 5), l3r, 1);
    end
    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

endmodule